// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the single bus master for a two-wire open-drain serial bus. It takes one request at a time from a simple command port and performs it on the wires. The four requests are: emit a START, emit a STOP, shift a byte out and collect the slave's acknowledge, or shift a byte in and answer with ACK or NACK. Both lines are modelled as open drain. An output-enable pulls a line low, and the real line level comes back through a two-flop synchronizer.

All bus timing is counted in microsecond steps from a prescaled tick. Each time the engine releases the clock line, it polls that line once per microsecond until it reads high. This lets a slave stretch the clock. If the line is still low after a set number of polls, the engine gives up, emits a STOP and reports an error. When a byte ends without a STOP, the engine leaves both lines pulled low, so the next request cannot produce a false START or STOP.

A request is taken while `busy` is low. `done` pulses once at the end of the request. The result outputs then hold until the next request completes.

Top module: `i2c_byte_master`

## Requirements
- R1: While reset is active and in the first cycle after it, both output-enables, `busy`, `done` and `err` are 0.
- R2: The START request (`cmd_op`=0) releases both lines for T_FREE µs. It then pulls SDA low while SCL reads high, holds for T_HOLD µs and pulls SCL low. It ends with both lines pulled low.
- R3: Outside START and STOP, the SDA enable changes only while SCL has been pulled low in that cycle and the one before. No START or STOP appears on the bus during a byte.
- R4: The write request (`cmd_op`=2) shifts `cmd_wdata` out MSB first, one bit per clock. It releases SDA for the ninth clock and samples it there. A low level sets `ack_ok`=1 and `err`=0.
- R5: A high level on the ninth clock of a write is a NACK: `ack_ok`=0 and `err`=1.
- R6: The read request (`cmd_op`=3) samples eight bits MSB first once SCL reads high, and returns them on `rd_data`.
- R7: On the ninth clock of a read, the engine drives SDA low when `cmd_last`=0 and leaves it high when `cmd_last`=1.
- R8: A write with `cmd_stop`=1 ends with a STOP. A read ends with a STOP only when `cmd_stop` and `cmd_last` are both 1. A STOP raises SCL with SDA low, waits T_HOLD µs, then releases SDA.
- R9: A byte that is not followed by a STOP leaves both lines pulled low. When idle, both enables are equal.
- R10: A slave that holds SCL low for fewer than POLL_MAX µs only lengthens the transfer. The data and status are unchanged.
- R11: When SCL stays low for POLL_MAX polls, the engine emits a STOP, sets `err`=1 and finishes with both lines released.
- R12: `busy` rises the cycle after a request is accepted. `done` is a single-cycle pulse while `busy` is low. A request made while busy is ignored. Results hold until the next request finishes.
- R13: The stop request (`cmd_op`=1) pulls SCL low, then pulls SDA low, then performs the STOP sequence, and ends with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request strobe, taken when busy is low |
| cmd_op | input | 2 | 0 start, 1 stop, 2 write byte, 3 read byte |
| cmd_last | input | 1 | Read: answer the byte with NACK |
| cmd_stop | input | 1 | Finish with a STOP (for reads only together with cmd_last) |
| cmd_wdata | input | 8 | Byte to transmit |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte received |
| ack_ok | output | 1 | Slave acknowledged the last written byte |
| err | output | 1 | Last request saw a NACK or a clock timeout |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |

## Verification
The hardest states to reach are a slave stretching the clock and a clock line that never comes back. Neither can arise from the command port alone. The bench's bus model therefore holds SCL low for a set number of cycles after every release, or pins it low for good. Stretching is set short enough to stay under the poll limit, and the transfer is compared with an unstretched one. The stuck case checks the error, the release of both lines and the time to give up. The bench then restores the bus with a fresh START and STOP.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FREE, S_SDAFALL, S_SHOLD,
    S_LOW, S_RISE, S_HIGH, S_FALL, S_PARK,
    S_PPRE, S_PDRV, S_PSETUP, S_FIN
  } st_e;
endpackage

// File: rtl/i2c_us_tick.sv
module i2c_us_tick #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == W'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk) begin
      if (rst) ff <= '1;
      else     ff <= {ff[STAGES-2:0], d[g]};
    end
    assign q[g] = ff[STAGES-1];
  end
endmodule

// File: rtl/i2c_bm_ctrl.sv
module i2c_bm_ctrl
  import i2c_bm_pkg::*;
#(
  parameter int T_FREE   = 5,
  parameter int T_LOW    = 5,
  parameter int T_HIGH   = 4,
  parameter int T_HOLD   = 4,
  parameter int POLL_MAX = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       scl_hi,
  input  logic       sda_hi,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_last,
  input  logic       cmd_stop,
  input  logic [7:0] cmd_wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       ack_ok,
  output logic       err,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int T_MAX = (T_FREE > T_LOW ? T_FREE : T_LOW) > (T_HIGH > T_HOLD ? T_HIGH : T_HOLD)
                       ? (T_FREE > T_LOW ? T_FREE : T_LOW) : (T_HIGH > T_HOLD ? T_HIGH : T_HOLD);
  localparam int TW = $clog2(T_MAX + 1);
  localparam int PW = $clog2(POLL_MAX + 1);

  st_e         state;
  op_e         cur_op;
  logic [7:0]  shreg;
  logic [3:0]  bit_idx;
  logic [TW-1:0] us_cnt;
  logic [TW-1:0] cur_len;
  logic [PW-1:0] poll_cnt;
  logic        f_last, f_stop, fail, ack_seen;
  logic        is_read, phase_end, poll_out;

  assign is_read = (cur_op == OP_READ);

  always_comb begin
    case (state)
      S_FREE:   cur_len = TW'(T_FREE);
      S_SHOLD:  cur_len = TW'(T_HOLD);
      S_LOW:    cur_len = TW'(T_LOW);
      S_HIGH:   cur_len = TW'(T_HIGH);
      S_PSETUP: cur_len = TW'(T_HOLD);
      default:  cur_len = TW'(1);
    endcase
  end

  assign phase_end = tick && (us_cnt == cur_len - TW'(1));
  assign poll_out  = (poll_cnt == PW'(POLL_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cur_op   <= OP_START;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
      ack_ok   <= 1'b0;
      err      <= 1'b0;
      shreg    <= '0;
      bit_idx  <= '0;
      us_cnt   <= '0;
      poll_cnt <= '0;
      f_last   <= 1'b0;
      f_stop   <= 1'b0;
      fail     <= 1'b0;
      ack_seen <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) us_cnt <= us_cnt + 1'b1;
      case (state)
        S_IDLE: if (cmd_valid) begin
          busy     <= 1'b1;
          fail     <= 1'b0;
          ack_seen <= 1'b0;
          us_cnt   <= '0;
          poll_cnt <= '0;
          bit_idx  <= '0;
          cur_op   <= op_e'(cmd_op);
          f_last   <= cmd_last;
          f_stop   <= cmd_stop;
          shreg    <= cmd_wdata;
          case (op_e'(cmd_op))
            OP_START: begin state <= S_FREE; scl_oe <= 1'b0; sda_oe <= 1'b0; end
            OP_STOP:  begin state <= S_PPRE; scl_oe <= 1'b1; end
            OP_WRITE: begin state <= S_LOW;  scl_oe <= 1'b1; sda_oe <= ~cmd_wdata[7]; end
            default:  begin state <= S_LOW;  scl_oe <= 1'b1; sda_oe <= 1'b0; end
          endcase
        end
        S_FREE: if (phase_end) begin
          state  <= S_SDAFALL;
          sda_oe <= 1'b1;
          us_cnt <= '0;
        end
        S_SDAFALL: if (tick) begin
          if (scl_hi) begin
            state  <= S_SHOLD;
            us_cnt <= '0;
          end else if (poll_out) begin
            fail   <= 1'b1;
            scl_oe <= 1'b1;
            state  <= S_PPRE;
          end else poll_cnt <= poll_cnt + 1'b1;
        end
        S_SHOLD: if (phase_end) begin
          scl_oe <= 1'b1;
          state  <= S_FIN;
        end
        S_LOW: if (phase_end) begin
          scl_oe   <= 1'b0;
          poll_cnt <= '0;
          state    <= S_RISE;
        end
        S_RISE: if (tick) begin
          if (scl_hi) begin
            state  <= S_HIGH;
            us_cnt <= '0;
            if (bit_idx == 4'd8) begin
              if (!is_read) begin
                ack_seen <= ~sda_hi;
                fail     <= fail | sda_hi;
              end
            end else if (is_read) begin
              shreg <= {shreg[6:0], sda_hi};
            end
          end else if (poll_out) begin
            fail   <= 1'b1;
            scl_oe <= 1'b1;
            state  <= S_PPRE;
          end else poll_cnt <= poll_cnt + 1'b1;
        end
        S_HIGH: if (phase_end) begin
          scl_oe <= 1'b1;
          state  <= S_FALL;
        end
        S_FALL: begin
          if (bit_idx == 4'd8) begin
            sda_oe <= 1'b1;
            state  <= S_PARK;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            us_cnt  <= '0;
            state   <= S_LOW;
            if (is_read) begin
              sda_oe <= (bit_idx == 4'd7) ? ~f_last : 1'b0;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= (bit_idx == 4'd7) ? 1'b0 : ~shreg[6];
            end
          end
        end
        S_PARK: begin
          if (f_stop && (!is_read || f_last)) begin
            scl_oe <= 1'b0;
            us_cnt <= '0;
            state  <= S_PSETUP;
          end else state <= S_FIN;
        end
        S_PPRE: begin
          sda_oe <= 1'b1;
          state  <= S_PDRV;
        end
        S_PDRV: begin
          scl_oe <= 1'b0;
          us_cnt <= '0;
          state  <= S_PSETUP;
        end
        S_PSETUP: if (phase_end) begin
          sda_oe <= 1'b0;
          state  <= S_FIN;
        end
        S_FIN: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          err   <= fail;
          state <= S_IDLE;
          if (cur_op == OP_WRITE) ack_ok <= ack_seen;
          if (is_read && !fail) rd_data <= shreg;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: SDA only moves under a held-low clock, outside START/STOP steps
  p_sda_under_low_scl_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && $past(state) != S_IDLE && $past(state) != S_FREE &&
     $past(state) != S_PSETUP) |-> (scl_oe && $past(scl_oe)));

  // R9: idle bus is either fully parked or fully released
  p_idle_bus_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> (scl_oe == sda_oe));

  // R12: handshake
  p_accept_r12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_not_busy_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11: a timeout always ends with an error report
  p_timeout_err_r11: assert property (@(posedge clk) disable iff (rst)
    (state == S_RISE && tick && !scl_hi && poll_out) |=> fail);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int CLK_PER_US  = 200,
  parameter int T_FREE      = 5,
  parameter int T_LOW       = 5,
  parameter int T_HIGH      = 4,
  parameter int T_HOLD      = 4,
  parameter int POLL_MAX    = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_last,
  input  logic       cmd_stop,
  input  logic [7:0] cmd_wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       ack_ok,
  output logic       err,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       scl_in,
  input  logic       sda_in
);
  logic       tick;
  logic [1:0] lines;

  i2c_us_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  i2c_line_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({sda_in, scl_in}), .q(lines)
  );

  i2c_bm_ctrl #(
    .T_FREE(T_FREE), .T_LOW(T_LOW), .T_HIGH(T_HIGH),
    .T_HOLD(T_HOLD), .POLL_MAX(POLL_MAX)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick),
    .scl_hi(lines[0]), .sda_hi(lines[1]),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_last(cmd_last),
    .cmd_stop(cmd_stop), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .ack_ok(ack_ok),
    .err(err), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
  localparam int DIV  = 4;
  localparam int POLL = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_last = 1'b0, cmd_stop = 1'b0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       busy, done, ack_ok, err, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic       scl_in, sda_in;

  // bus and slave model
  int   stretch_len = 0;
  int   rel_cnt = 0;
  bit   stuck = 1'b0;
  bit   s_on = 1'b0, s_read = 1'b0, s_ack = 1'b0;
  logic [7:0] s_byte = 8'h00;
  bit   mon_clr = 1'b0;
  int   fcnt = 0, nrise = 0, nstart = 0, nstop = 0;
  logic [8:0] cap = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic slave_pull;

  assign slave_pull = s_on && (s_read ? (fcnt < 8 && !s_byte[7 - (fcnt & 7)]) : (fcnt == 8 && s_ack));
  assign scl_in = !scl_oe && !stuck && (rel_cnt >= stretch_len);
  assign sda_in = !sda_oe && !slave_pull;

  i2c_byte_master #(.CLK_PER_US(DIV), .POLL_MAX(POLL)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_last(cmd_last), .cmd_stop(cmd_stop), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .ack_ok(ack_ok), .err(err),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in)
  );

  always @(posedge clk) begin
    if (scl_oe) rel_cnt <= 0;
    else if (rel_cnt < 100000) rel_cnt <= rel_cnt + 1;
    prev_scl <= scl_in;
    prev_sda <= sda_in;
    if (mon_clr) begin
      fcnt <= 0; nrise <= 0; cap <= '0;
    end else begin
      if (prev_scl && !scl_in) fcnt <= fcnt + 1;
      if (!prev_scl && scl_in && nrise < 9) begin
        cap   <= {cap[7:0], sda_in};
        nrise <= nrise + 1;
      end
    end
    if (prev_scl && scl_in && prev_sda && !sda_in) nstart <= nstart + 1;
    if (prev_scl && scl_in && !prev_sda && sda_in) nstop <= nstop + 1;
  end

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic last, input logic stop, input logic [7:0] wd);
    @(negedge clk);
    cmd_op = op; cmd_last = last; cmd_stop = stop; cmd_wdata = wd;
    cmd_valid = 1'b1; mon_clr = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk("R12 watchdog", 0, 1);
  endtask

  typedef struct packed {
    logic [1:0] op;
    logic       last;
    logic       stop;
    logic [7:0] wd;
    logic [7:0] sb;
    logic       sack;
    logic       xerr;
    logic [8:0] xcap;
    logic       dstart;
    logic       dstop;
    logic       parked;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 9'h000, 1'b1, 1'b0, 1'b1},
    '{2'd2, 1'b0, 1'b0, 8'hA5, 8'h00, 1'b1, 1'b0, 9'h14A, 1'b0, 1'b0, 1'b1},
    '{2'd3, 1'b0, 1'b1, 8'h00, 8'h3C, 1'b0, 1'b0, 9'h078, 1'b0, 1'b0, 1'b1},
    '{2'd3, 1'b1, 1'b1, 8'h00, 8'hC3, 1'b0, 1'b0, 9'h187, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 9'h000, 1'b1, 1'b0, 1'b1},
    '{2'd2, 1'b0, 1'b1, 8'h5A, 8'h00, 1'b0, 1'b1, 9'h0B5, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 9'h000, 1'b1, 1'b0, 1'b1},
    '{2'd2, 1'b0, 1'b1, 8'h81, 8'h00, 1'b1, 1'b0, 9'h102, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 9'h000, 1'b1, 1'b0, 1'b1},
    '{2'd2, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 9'h000, 1'b0, 1'b0, 1'b1},
    '{2'd1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 9'h000, 1'b0, 1'b1, 1'b0}
  };

  task automatic run_vec(input vec_t v, input string tag);
    int st0, sp0, cyc;
    s_on = (v.op >= 2'd2); s_read = (v.op == 2'd3); s_byte = v.sb; s_ack = v.sack;
    st0 = nstart; sp0 = nstop;
    issue(v.op, v.last, v.stop, v.wd);
    chk({tag, " R12 busy"}, busy, 1);
    wait_done(cyc);
    chk({tag, " R5 err"}, err, v.xerr);
    if (v.op == 2'd2) begin
      chk({tag, " R4 bits"}, cap, v.xcap);
      chk({tag, " R4 ack_ok"}, ack_ok, v.sack);
    end
    if (v.op == 2'd3) begin
      chk({tag, " R6 rd_data"}, rd_data, v.sb);
      chk({tag, " R7 ninth bit"}, cap[0], v.last);
    end
    @(negedge clk);
    chk({tag, " R2 start count"}, nstart - st0, v.dstart);
    chk({tag, " R8 stop count"}, nstop - sp0, v.dstop);
    chk({tag, " R9 bus state"}, {scl_oe, sda_oe}, v.parked ? 2'b11 : 2'b00);
    s_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R12 global watchdog got=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base, slow, cyc, st0, sp0;
    repeat (5) @(negedge clk);
    chk("R1 reset outputs", {scl_oe, sda_oe, busy, done, err}, 5'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {scl_oe, sda_oe, busy, done, err}, 5'b0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], $sformatf("vec%0d", i));

    // R12: results hold, request while busy is ignored
    repeat (30) @(negedge clk);
    chk("R12 rd_data held", rd_data, 8'hC3);
    issue(2'd0, 0, 0, 0);
    wait_done(cyc);
    s_on = 1'b1; s_read = 1'b0; s_ack = 1'b1;
    sp0 = nstop;
    issue(2'd2, 0, 0, 8'h6E);
    repeat (40) @(negedge clk);
    cmd_op = 2'd1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(base);
    chk("R12 busy request ignored bits", cap, {8'h6E, 1'b0});
    repeat (200) @(negedge clk);
    chk("R12 no extra stop", nstop - sp0, 0);
    chk("R12 idle after ignore", busy, 0);

    // R10: clock stretching
    stretch_len = 40;
    issue(2'd2, 0, 0, 8'h6E);
    wait_done(slow);
    stretch_len = 0;
    chk("R10 stretched bits", cap, {8'h6E, 1'b0});
    chk("R10 stretched no err", err, 0);
    chk("R10 stretch lengthens", slow > base + 200, 1);
    s_read = 1'b1; s_byte = 8'h96; stretch_len = 30;
    issue(2'd3, 0, 0, 0);
    wait_done(cyc);
    stretch_len = 0;
    chk("R10 stretched read", rd_data, 8'h96);

    // R11: stuck clock
    s_on = 1'b0;
    stuck = 1'b1;
    sp0 = nstop;
    issue(2'd2, 0, 0, 8'hFF);
    wait_done(cyc);
    chk("R11 timeout err", err, 1);
    chk("R11 give-up time", (cyc > POLL * DIV - 10) && (cyc < POLL * DIV + 200), 1);
    @(negedge clk);
    chk("R11 lines released", {scl_oe, sda_oe}, 2'b00);
    chk("R11 no stop seen on stuck bus", nstop - sp0, 0);
    stuck = 1'b0;
    st0 = nstart; sp0 = nstop;
    issue(2'd0, 0, 0, 0);
    wait_done(cyc);
    chk("R2 recovery start err", err, 0);
    issue(2'd1, 0, 0, 0);
    wait_done(cyc);
    @(negedge clk);
    chk("R13 recovery start+stop", {nstart - st0, nstop - sp0}, {32'd1, 32'd1});
    chk("R3 no spurious conditions", nstart, 6);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule